// File: doc/BRIEF.md
# Bitmap Column-Layout Address Translator

This block sits between the video controller's 14-bit fetch address and the memory address decoder. Bitmap data held in cell order (each 8x8 cell stored as eight consecutive bytes) is instead stored as 40 vertical byte columns. Each column is one contiguous 256-byte run, and one byte holds one pixel line of that column. A renderer can then step down a column by incrementing a pointer, with no cell arithmetic.

Only 200 of the 256 bytes in a column are shown. A per-column start offset, written by the CPU, selects which byte appears on the top line. Reading wraps inside the column's own 256-byte region, so scrolling a column or flipping between buffers needs only a one-byte write. Screen-matrix and colour fetches are not touched. The translation is purely combinational, so it adds no fetch latency.

Top module: `colmap_xlate`

## Requirements
- R1: When `bmp_fetch` is 0 (screen-matrix or colour fetch), `maddr` equals `vaddr` zero-extended to 16 bits.
- R2: For a bitmap fetch, `vaddr[2:0]` is the line within a cell and `vaddr[12:3]` is the cell index. The column is index mod 40 and the cell row is index / 40. `vaddr[13]` has no effect on a translated address.
- R3: A translated address is `COL_BASE + column*256 + ((cell_row*8 + line_in_cell + offset[column]) mod 256)`, with `COL_BASE` defaulting to 0x4000.
- R4: The byte position wraps modulo 256 inside the column's region and never carries into the column number.
- R5: A write (`cfg_we` high at a rising clock edge, `cfg_sel` below 40) loads `cfg_data` into the offset of column `cfg_sel`. The new offset applies from the next cycle and changes no other column's offset.
- R6: A write with `cfg_sel` of 40 or more changes no offset.
- R7: While `rst_n` is low at a rising edge, every column offset is cleared to 0.
- R8: A bitmap fetch whose cell index is 1000 to 1023 passes through like R1.
- R9: `maddr` follows `vaddr` and `bmp_fetch` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the offset registers |
| rst_n | input | 1 | Synchronous active-low reset |
| vaddr | input | 14 | Video fetch address |
| bmp_fetch | input | 1 | 1 = bitmap data fetch, 0 = matrix or colour fetch |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_sel | input | 6 | Column selected for the write |
| cfg_data | input | 8 | Start offset to store |
| maddr | output | 16 | Memory address after translation |

## Verification
A corrupted offset register shows at the ports only when its own column is fetched. The bench therefore reads back every written column, and also a neighbouring column, in the cycle after the write edge. A wrong quotient or remainder in the divide-by-40 moves the address into another 256-byte region. This is exposed at once by fetches on the cell boundaries 39/40 and 959/960 and at the last valid index 999. A missing modulo shows as a carry into the column bits, which is caught by an offset large enough that the line sum passes 255.

// File: rtl/colmap_pkg.sv
// Package: shared geometry constants and types for the column translator.
// Assumes a 40-column, 25-cell-row bitmap with 8 lines per cell.
package colmap_pkg;
    localparam int VADDR_W    = 14;
    localparam int MADDR_W    = 16;
    localparam int NUM_COLS   = 40;
    localparam int CELL_ROWS  = 25;
    localparam int LINES_CELL = 8;
    localparam int OFS_W      = 8;
    localparam int LIN_W      = $clog2(LINES_CELL);
    localparam int SEL_W      = $clog2(NUM_COLS);
    localparam int CROW_W     = $clog2(CELL_ROWS);
    localparam int CIDX_W     = 10;
    localparam int NUM_CELLS  = NUM_COLS * CELL_ROWS;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [SEL_W-1:0]  col_t;
    typedef logic [CROW_W-1:0] crow_t;
endpackage

// File: rtl/colmap_offset_bank.sv
// Module: per-column start-offset register bank.
// Stores one offset per column and offers one combinational read port.
// Assumes writes to a select at or above NUM_COLS are dropped.
module colmap_offset_bank
    import colmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  col_t wr_sel,
    input  ofs_t wr_data,
    input  col_t rd_col,
    output ofs_t rd_ofs
);
    ofs_t ofs_q [NUM_COLS];

    // Clear every register in reset, otherwise load the selected column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_COLS; i++) ofs_q[i] <= '0;
        end else if (wr_en && (int'(wr_sel) < NUM_COLS)) begin
            ofs_q[wr_sel] <= wr_data;
        end
    end

    // Read the offset of the column being fetched.
    always_comb begin
        rd_ofs = '0;
        if (int'(rd_col) < NUM_COLS) rd_ofs = ofs_q[rd_col];
    end
endmodule

// File: rtl/colmap_cell_split.sv
// Module: splits a cell index into cell row (index / NUM_COLS) and column.
// Purely combinational threshold compare, no multiplier or divider.
// Flags indices at or beyond NUM_CELLS as outside the visible area.
module colmap_cell_split
    import colmap_pkg::*;
(
    input  logic [CIDX_W-1:0] cell_idx,
    output crow_t             cell_row,
    output col_t              col,
    output logic              in_area
);
    logic [CELL_ROWS-1:0] ge;
    assign ge[0] = 1'b1;

    // One comparator for each row boundary.
    for (genvar g = 1; g < CELL_ROWS; g++) begin : g_thr
        assign ge[g] = (int'(cell_idx) >= g * NUM_COLS);
    end

    // Count the boundaries passed, then take the remainder.
    always_comb begin
        int q;
        int rem;
        q = 0;
        for (int i = 1; i < CELL_ROWS; i++) q = q + int'(ge[i]);
        rem      = int'(cell_idx) - q * NUM_COLS;
        cell_row = crow_t'(q);
        col      = col_t'(rem);
        in_area  = (int'(cell_idx) < NUM_CELLS);
    end
endmodule

// File: rtl/colmap_addr_compose.sv
// Module: builds the final memory address from the decoded fields.
// The line sum wraps in OFS_W bits and never carries into the column.
module colmap_addr_compose
    import colmap_pkg::*;
#(
    parameter logic [MADDR_W-1:0] COL_BASE = 16'h4000
) (
    input  logic [VADDR_W-1:0] vaddr,
    input  logic               xlate,
    input  crow_t              cell_row,
    input  logic [LIN_W-1:0]   line_in_cell,
    input  col_t               col,
    input  ofs_t               ofs,
    output logic [MADDR_W-1:0] maddr
);
    localparam int REL_W = SEL_W + OFS_W;

    ofs_t             line_pos;
    ofs_t             byte_pos;
    logic [REL_W-1:0] rel;

    // Add the column offset to the screen line, modulo 256.
    always_comb begin
        line_pos = ofs_t'({cell_row, line_in_cell});
        byte_pos = line_pos + ofs;
        rel      = {col, byte_pos};
    end

    // Select the translated or the untouched address.
    always_comb begin
        if (xlate) maddr = COL_BASE + MADDR_W'(rel);
        else       maddr = MADDR_W'(vaddr);
    end
endmodule

// File: rtl/colmap_xlate.sv
// Module: top of the bitmap column-layout address translator.
// Assumes bmp_fetch is valid in the same cycle as vaddr. The output path
// is combinational. Only the offset registers are clocked.
module colmap_xlate
    import colmap_pkg::*;
#(
    parameter logic [MADDR_W-1:0] COL_BASE = 16'h4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VADDR_W-1:0] vaddr,
    input  logic               bmp_fetch,
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [OFS_W-1:0]   cfg_data,
    output logic [MADDR_W-1:0] maddr
);
    crow_t cell_row;
    col_t  col;
    logic  in_area;
    ofs_t  col_ofs;
    logic  xlate;

    colmap_offset_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_data),
        .rd_col  (col),
        .rd_ofs  (col_ofs)
    );

    colmap_cell_split u_split (
        .cell_idx (vaddr[LIN_W +: CIDX_W]),
        .cell_row (cell_row),
        .col      (col),
        .in_area  (in_area)
    );

    // Translate only bitmap fetches inside the visible cell range.
    assign xlate = bmp_fetch && in_area;

    colmap_addr_compose #(.COL_BASE(COL_BASE)) u_comp (
        .vaddr        (vaddr),
        .xlate        (xlate),
        .cell_row     (cell_row),
        .line_in_cell (vaddr[LIN_W-1:0]),
        .col          (col),
        .ofs          (col_ofs),
        .maddr        (maddr)
    );
endmodule

// File: rtl/colmap_xlate_chk.sv
// Checker: port-level properties of colmap_xlate, bound to the top module.
module colmap_xlate_chk
    import colmap_pkg::*;
#(
    parameter logic [MADDR_W-1:0] COL_BASE = 16'h4000
) (
    input logic               clk,
    input logic               rst_n,
    input logic [VADDR_W-1:0] vaddr,
    input logic               bmp_fetch,
    input logic               cfg_we,
    input logic [SEL_W-1:0]   cfg_sel,
    input logic [OFS_W-1:0]   cfg_data,
    input logic [MADDR_W-1:0] maddr
);
    logic [CIDX_W-1:0] idx;
    logic [MADDR_W-1:0] rel;
    assign idx = vaddr[12:3];
    assign rel = maddr - COL_BASE;

    // R1
    pass_mat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bmp_fetch |-> maddr == {2'b00, vaddr});

    // R8
    pass_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmp_fetch && int'(idx) >= NUM_CELLS) |-> maddr == {2'b00, vaddr});

    // R2
    col_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmp_fetch && int'(idx) < NUM_CELLS) |-> int'(rel[15:8]) == int'(idx) % NUM_COLS);

    // R4
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bmp_fetch && int'(idx) < NUM_CELLS) |-> int'(rel) < NUM_COLS * 256);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we) && $stable(vaddr) && $stable(bmp_fetch)) |-> $stable(maddr));
endmodule

bind colmap_xlate colmap_xlate_chk #(.COL_BASE(COL_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vaddr     (vaddr),
    .bmp_fetch (bmp_fetch),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .maddr     (maddr)
);

// File: tb/test_colmap_xlate.sv
// Directed bench for colmap_xlate: one task for each scenario.
module test_colmap_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 16'h4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] vaddr;
    logic        bmp_fetch;
    logic        cfg_we;
    logic [5:0]  cfg_sel;
    logic [7:0]  cfg_data;
    logic [15:0] maddr;

    int checks = 0;
    int errors = 0;
    int model_ofs [40];

    colmap_xlate i_colmap_xlate (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .bmp_fetch(bmp_fetch),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .maddr(maddr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int expect_addr(input int va, input bit bmp);
        int idx;
        int col;
        int crow;
        idx = (va >> 3) & 1023;
        if (!bmp || idx >= 1000) return va;
        col  = idx % 40;
        crow = idx / 40;
        return BASE + col * 256 + ((crow * 8 + (va & 7) + model_ofs[col]) % 256);
    endfunction

    task automatic probe(input int va, input bit bmp, input string req);
        int exp;
        vaddr = 14'(va);
        bmp_fetch = bmp;
        #1;
        exp = expect_addr(va, bmp);
        checks++;
        if (int'(maddr) != exp) begin
            errors++;
            $display("FAIL %s vaddr=%h bmp=%0d actual=%h expected=%h", req, va, bmp, maddr, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 6'(sel); cfg_data = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 40) model_ofs[sel] = data & 255;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) model_ofs[i] = 0;
    endtask

    // R7: all offsets zero after reset
    task automatic t_reset_state();
        do_reset();
        probe(14'h0000, 1, "R7");
        probe(14'h1F3F, 1, "R7");
    endtask

    // R1: matrix and colour fetches pass through
    task automatic t_passthrough();
        cfg_write(3, 77);
        probe(14'h0018, 0, "R1");
        probe(14'h3FFF, 0, "R1");
        probe(14'h2ABC, 0, "R1");
    endtask

    // R2/R3: decode on cell boundaries, bit 13 ignored; R9 same-cycle
    task automatic t_layout();
        probe(39 * 8 + 7, 1, "R2");
        probe(40 * 8, 1, "R2");
        probe(959 * 8 + 5, 1, "R3");
        probe(960 * 8, 1, "R3");
        probe(999 * 8 + 7, 1, "R3");
        probe(14'h2000 | (41 * 8 + 2), 1, "R2");
        probe(123 * 8 + 4, 1, "R9");
    endtask

    // R5/R4: write offsets, wrap modulo 256 without column carry
    task automatic t_offsets();
        cfg_write(0, 200);
        cfg_write(39, 255);
        probe(960 * 8 + 7, 1, "R4");
        probe(999 * 8 + 7, 1, "R4");
        probe(0, 1, "R5");
        probe(1 * 8, 1, "R5");
        probe(38 * 8 + 1, 1, "R5");
    endtask

    // R6: out-of-range select leaves every offset alone
    task automatic t_ignored_write();
        cfg_write(45, 99);
        cfg_write(63, 12);
        for (int c = 0; c < 40; c++) probe(c * 8 + 3, 1, "R6");
    endtask

    // R8: cell indices beyond 999 pass through
    task automatic t_out_of_area();
        probe(1000 * 8, 1, "R8");
        probe(1023 * 8 + 7, 1, "R8");
        probe(14'h2000 | (1010 * 8 + 1), 1, "R8");
    endtask

    // R7: reset clears written offsets
    task automatic t_reset_clears();
        cfg_write(5, 44);
        probe(5 * 8, 1, "R5");
        do_reset();
        probe(5 * 8, 1, "R7");
        probe(39 * 8, 1, "R7");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vaddr = '0; bmp_fetch = 1'b0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
        for (int i = 0; i < 40; i++) model_ofs[i] = 0;
        t_reset_state();
        t_passthrough();
        t_layout();
        t_offsets();
        t_ignored_write();
        t_out_of_area();
        t_reset_clears();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule